// File: doc/BRIEF.md
# Set/Clear Register GPIO Bank

A bank of 32 general-purpose I/O pins steered through a small memory-mapped register port. Software never writes the output-value or direction vectors whole. It writes masks to strobe registers instead: one mask sets output bits, one clears output bits, and one returns pins to input. A single pin can therefore change without a read-modify-write sequence, and two agents that own disjoint pins cannot overwrite each other's bits.

Direction follows from use. Any write to the set or clear register also turns on the output driver of every pin selected by the mask. Only a write to the tristate-clear register turns a driver off again. Pad input levels pass through a two-flop synchronizer and are read back through a pin-state register. Interrupt routing and pin multiplexing sit outside this block.

The register port has single-cycle writes. Read data is registered and returned one cycle after the request, together with a one-cycle response-valid pulse.

Top module: `gpio_setclr_bank`

## Requirements
- R1: While reset is asserted and after it is released, every pin is an input (`pad_oe_o` all zero), every output value is 0, and `rsp_valid_o` is low.
- R2: A write to word index 1 (output-set) makes `pad_out_o` 1 on every pin whose data bit is 1. All other output bits keep their value. The result is visible one clock after the write.
- R3: A write to word index 2 (output-clear) makes `pad_out_o` 0 on every pin whose data bit is 1. All other output bits keep their value.
- R4: A write to word index 1 or 2 also sets `pad_oe_o` on every pin whose data bit is 1. The enables of all other pins are left unchanged.
- R5: A write to word index 0 (tristate-clear) clears `pad_oe_o` on every pin whose data bit is 1. It does not change any output value or any other enable.
- R6: A write whose data is all zero, to any index, changes neither `pad_out_o` nor `pad_oe_o`. The same holds for any cycle without a write.
- R7: A read of word index 3 returns the pad levels after a two-flop synchronizer. A pad change made before clock edge k is returned by a read that is sampled at edge k+2, and not by reads sampled at edges k or k+1.
- R8: A read of word index 0 or 2 returns the current output-enable vector, and a read of index 1 returns the current output-value vector. Reads never change pin state.
- R9: `rsp_valid_o` is high for exactly the one cycle after a read request, and low after writes and idle cycles. `rsp_rdata_o` carries the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2 | Register word index (byte offset / 4) |
| req_wdata_i | input | 32 | Write mask |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata_o | output | 32 | Read data |
| pad_in_i | input | 32 | Pad input levels (asynchronous) |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables (1 = drive) |

## Verification
A corrupted per-pin flop shows up on `pad_out_o` or `pad_oe_o` at the first clock after the write that touched it. It also shows up on a read-back of index 0, 1 or 2 one cycle after the read request. Stimulus with mixed masks probes the mask handling: a wrong mask decode or a swapped strobe moves pins that should not move, and the unselected bits of every write are compared. A synchronizer that is too short or too long returns the new pad level one read too early or one read too late, so three reads in a row after a pad change pin down its depth.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;

  localparam int unsigned REG_IDX_W = 2;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_TRI_CLR   = 2'd0,
    REG_OUT_SET   = 2'd1,
    REG_OUT_CLR   = 2'd2,
    REG_PIN_STATE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic tri_clr;
    logic out_set;
    logic out_clr;
    logic rd;
  } strobe_t;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_setclr_pkg::*;
(
  input  logic                 valid_i,
  input  logic                 write_i,
  input  logic [REG_IDX_W-1:0] addr_i,
  output reg_sel_e             sel_o,
  output strobe_t              strb_o
);

  always_comb begin
    sel_o  = reg_sel_e'(addr_i);
    strb_o = '0;
    if (valid_i) begin
      if (!write_i) begin
        strb_o.rd = 1'b1;
      end else begin
        unique case (sel_o)
          REG_TRI_CLR: strb_o.tri_clr = 1'b1;
          REG_OUT_SET: strb_o.out_set = 1'b1;
          REG_OUT_CLR: strb_o.out_clr = 1'b1;
          default:     ; // pin state is read-only
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tri_clr_i,
  input  logic out_set_i,
  input  logic out_clr_i,
  input  logic mask_i,
  output logic out_o,
  output logic oe_o
);

  logic out_q, oe_q;

  // strobes are mutually exclusive from the decoder
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (mask_i) begin
      if (out_set_i) begin
        out_q <= 1'b1;
        oe_q  <= 1'b1;
      end else if (out_clr_i) begin
        out_q <= 1'b0;
        oe_q  <= 1'b1;
      end else if (tri_clr_i) begin
        oe_q  <= 1'b0;
      end
    end
  end

  assign out_o = out_q;
  assign oe_o  = oe_q;

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_write_i,
  input  logic [REG_IDX_W-1:0] req_addr_i,
  input  logic [NUM_PINS-1:0]  req_wdata_i,
  output logic                 rsp_valid_o,
  output logic [NUM_PINS-1:0]  rsp_rdata_o,
  input  logic [NUM_PINS-1:0]  pad_in_i,
  output logic [NUM_PINS-1:0]  pad_out_o,
  output logic [NUM_PINS-1:0]  pad_oe_o
);

  reg_sel_e            sel;
  strobe_t             strb;
  logic [NUM_PINS-1:0] out_vec, oe_vec, pin_sync;
  logic [NUM_PINS-1:0] rd_mux;
  logic [NUM_PINS-1:0] rdata_q;
  logic                rvalid_q;

  gpio_reg_decode u_decode (
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .addr_i  (req_addr_i),
    .sel_o   (sel),
    .strb_o  (strb)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tri_clr_i (strb.tri_clr),
      .out_set_i (strb.out_set),
      .out_clr_i (strb.out_clr),
      .mask_i    (req_wdata_i[p]),
      .out_o     (out_vec[p]),
      .oe_o      (oe_vec[p])
    );
  end

  gpio_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_sync)
  );

  always_comb begin
    unique case (sel)
      REG_OUT_SET:   rd_mux = out_vec;
      REG_PIN_STATE: rd_mux = pin_sync;
      default:       rd_mux = oe_vec;  // tri-clear and out-clear offsets
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= strb.rd;
      if (strb.rd) rdata_q <= rd_mux;
    end
  end

  assign rsp_valid_o = rvalid_q;
  assign rsp_rdata_o = rdata_q;
  assign pad_out_o   = out_vec;
  assign pad_oe_o    = oe_vec;

endmodule

// File: rtl/gpio_setclr_bank_chk.sv
module gpio_setclr_bank_chk
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_write_i,
  input logic [REG_IDX_W-1:0] req_addr_i,
  input logic [NUM_PINS-1:0]  req_wdata_i,
  input logic                 rsp_valid_o,
  input logic [NUM_PINS-1:0]  pad_out_o,
  input logic [NUM_PINS-1:0]  pad_oe_o
);

  logic wr_set, wr_clr, wr_tri, rd_req;
  assign wr_set = req_valid_i && req_write_i && (req_addr_i == REG_OUT_SET);
  assign wr_clr = req_valid_i && req_write_i && (req_addr_i == REG_OUT_CLR);
  assign wr_tri = req_valid_i && req_write_i && (req_addr_i == REG_TRI_CLR);
  assign rd_req = req_valid_i && !req_write_i;

  always_comb begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (pad_oe_o == '0 && pad_out_o == '0 && !rsp_valid_o);
    end
  end

  assert_set_drives_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> (pad_out_o & $past(req_wdata_i)) == $past(req_wdata_i));

  assert_clr_drives_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> (pad_out_o & $past(req_wdata_i)) == '0);

  assert_write_enables_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_set || wr_clr) |=> (pad_oe_o & $past(req_wdata_i)) == $past(req_wdata_i));

  assert_tri_disables_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tri |=> ((pad_oe_o & $past(req_wdata_i)) == '0) && $stable(pad_out_o));

  assert_idle_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_write_i) |=> $stable(pad_out_o) && $stable(pad_oe_o));

  assert_rsp_follows_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rsp_valid_o);

  assert_rsp_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rsp_valid_o);

endmodule

bind gpio_setclr_bank gpio_setclr_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .rsp_valid_o (rsp_valid_o),
  .pad_out_o   (pad_out_o),
  .pad_oe_o    (pad_oe_o)
);

// File: tb/gpio_setclr_bank_tb.sv
`timescale 1ns/1ps
module gpio_setclr_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_out = '0;
  logic [31:0] exp_oe  = '0;

  always #2 clk = ~clk;

  gpio_setclr_bank dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_write_i (req_write),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata),
    .pad_in_i    (pad_in),
    .pad_out_o   (pad_out),
    .pad_oe_o    (pad_oe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    check({req, " out"}, pad_out, exp_out);
    check({req, " oe"}, pad_oe, exp_oe);
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic wr(logic [1:0] idx, logic [31:0] data);
    req_valid = 1'b1; req_write = 1'b1; req_addr = idx; req_wdata = data;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    case (idx)
      2'd0: exp_oe = exp_oe & ~data;
      2'd1: begin exp_out = exp_out | data; exp_oe = exp_oe | data; end
      2'd2: begin exp_out = exp_out & ~data; exp_oe = exp_oe | data; end
      default: ;
    endcase
  endtask

  task automatic rd(logic [1:0] idx, output logic [31:0] data, output logic vld);
    req_valid = 1'b1; req_write = 1'b0; req_addr = idx;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    data = rsp_rdata;
    vld  = rsp_valid;
  endtask

  task automatic t_reset;
    check("R1 oe in reset", pad_oe, '0);
    check("R1 out in reset", pad_out, '0);
    check("R1 rsp_valid in reset", {31'd0, rsp_valid}, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after release");
  endtask

  task automatic t_set;
    wr(2'd1, 32'h0000_00F0);
    check_state("R2/R4 set F0");
    wr(2'd1, 32'h0000_0001);
    check_state("R2 set bit0 keeps others");
  endtask

  task automatic t_clear;
    wr(2'd2, 32'h0000_0030);
    check_state("R3 clear 30");
    wr(2'd2, 32'hFF00_0000);
    check_state("R4 clear enables input pins");
  endtask

  task automatic t_tristate;
    wr(2'd0, 32'h0000_0081);
    check_state("R5 tristate-clear 81");
    wr(2'd0, 32'h0F00_0000);
    check_state("R5 tristate-clear upper");
  endtask

  task automatic t_zero;
    for (int i = 0; i < 4; i++) begin
      wr(2'(i), 32'h0);
      check_state("R6 zero-mask write");
    end
    repeat (3) @(negedge clk);
    check_state("R6 idle cycles");
  endtask

  task automatic t_readback;
    logic [31:0] d; logic v;
    rd(2'd0, d, v); check("R8 read idx0 = oe", d, exp_oe); check("R9 valid idx0", {31'd0, v}, 32'd1);
    rd(2'd1, d, v); check("R8 read idx1 = out", d, exp_out);
    rd(2'd2, d, v); check("R8 read idx2 = oe", d, exp_oe);
    check_state("R8 reads leave state");
  endtask

  task automatic t_sync;
    logic [31:0] d; logic v;
    pad_in = 32'hA5A5_1234;
    repeat (3) @(negedge clk);
    rd(2'd3, d, v); check("R7 settled pad", d, 32'hA5A5_1234);
    pad_in = 32'h5A5A_8001;
    rd(2'd3, d, v); check("R7 edge k old", d, 32'hA5A5_1234);
    rd(2'd3, d, v); check("R7 edge k+1 old", d, 32'hA5A5_1234);
    rd(2'd3, d, v); check("R7 edge k+2 new", d, 32'h5A5A_8001);
    check_state("R8 pin-state read leaves state");
  endtask

  task automatic t_rsp;
    logic [31:0] d; logic v;
    rd(2'd1, d, v);
    check("R9 valid after read", {31'd0, v}, 32'd1);
    check("R9 rdata after read", d, exp_out);
    @(negedge clk);
    check("R9 valid drops after idle", {31'd0, rsp_valid}, 32'd0);
    wr(2'd1, 32'h0000_0100);
    check("R9 no valid after write", {31'd0, rsp_valid}, 32'd0);
    check_state("R2 set after reads");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_set();
    t_clear();
    t_tristate();
    t_zero();
    t_readback();
    t_sync();
    t_rsp();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule